// File: doc/BRIEF.md
# Horizontal Drive Soft Start/Stop and Protection Sequencer

This block decides when the horizontal deflection drive of a picture-tube display may run. It raises the drive duty gradually when the display is switched on and lowers it the same way when it is switched off. After a switch-off it runs a timed picture-tube discharge phase, either by driving the RGB outputs for a small discharge current or by blanking them.

The block also watches three protection comparators: X-ray over-voltage, vertical guard failure and flash. Each one sets a sticky status flag. An enable bit for each one chooses whether the event only sets its flag or also acts on the drive or the RGB outputs. Analog comparators are modelled as one-bit flags. The ramp generator is modelled as a duty counter that advances on line-period ticks.

Top module: `hdrive_guard_seq`

## Requirements
- R1: The drive (`hdrv_en`) may start only while `por_flag`=0, `cfg_done`=1, `run_req`=1 and no protection stop is latched. If any of these is missing, the block stays off.
- R2: On start, `duty` begins at 0 and rises by one after every STEP_LINES line ticks. One cycle after it reaches its maximum (all ones), the ramp ends and `duty` stays at the maximum.
- R3: Cycles without `line_tick` do not advance the ramp or its step phase.
- R4: When permission is lost, `duty` falls by one after every STEP_LINES line ticks while `hdrv_en` stays 1. One cycle after `duty` reaches 0, `hdrv_en` goes to 0.
- R5: A change of permission during a ramp reverses the ramp from its current level. The step phase is kept, so no step is lost or repeated.
- R6: After the soft stop, a discharge phase lasts DIS_LINES line ticks and then the block returns to off. In this phase, with `blk_force`=0, `discharge_on`=1 and `rgb_blank`=0. With `blk_force`=1, `discharge_on`=0 and `rgb_blank`=1.
- R7: An `xray_trip` sets `stat_xray` until reset. With `xray_flag_only`=0 it also sets `stat_kill`, which forces a soft stop with discharge and blocks any restart until reset.
- R8: With `xray_flag_only`=1, an X-ray event only sets `stat_xray`. The drive keeps running at full duty.
- R9: A `vguard_fail` sets `stat_vguard` until reset. With `vguard_blank_en`=1 it also drives `rgb_blank` high in the same cycle, for as long as the failure lasts. With `vguard_blank_en`=0 the RGB outputs are not affected.
- R10: A `flash_trip` sets `stat_flash` until reset. With `flash_ignore`=0 it also latches `stat_kill` and forces a soft stop. With `flash_ignore`=1 the drive keeps running.
- R11: `overscan_hold` is 1 exactly while `overscan_hold_en`=1 and the block is ramping down or discharging.
- R12: `rgb_low_req`=1 forces `rgb_blank`=1 and `bcl_en`=0 (black-current loop off). `bcl_en` is the inverse of `rgb_blank`.
- R13: After reset, all outputs and all status flags are 0, except `bcl_en`, which is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| line_tick | input | 1 | One-cycle pulse per line period |
| run_req | input | 1 | 1 = operational, 0 = standby |
| cfg_done | input | 1 | All control registers have been loaded |
| por_flag | input | 1 | Power-on-reset indication; 1 blocks the drive |
| blk_force | input | 1 | Discharge style: 1 = blank RGB instead of discharge current |
| rgb_low_req | input | 1 | Force RGB low and turn off the black-current loop |
| xray_flag_only | input | 1 | 1 = X-ray event only sets its flag |
| vguard_blank_en | input | 1 | 1 = vertical guard failure blanks RGB |
| flash_ignore | input | 1 | 1 = flash event cannot stop the drive |
| overscan_hold_en | input | 1 | Hold vertical deflection in top overscan during switch-off |
| xray_trip | input | 1 | X-ray comparator flag |
| vguard_fail | input | 1 | Vertical guard comparator flag |
| flash_trip | input | 1 | Flash comparator flag |
| hdrv_en | output | 1 | Horizontal drive enable |
| duty | output | LEVEL_W | Soft-ramp duty level |
| rgb_blank | output | 1 | RGB outputs forced low |
| bcl_en | output | 1 | Black-current loop enable |
| discharge_on | output | 1 | RGB driven for tube discharge current |
| overscan_hold | output | 1 | Request to hold vertical deflection in top overscan |
| stat_xray | output | 1 | Latched X-ray event |
| stat_vguard | output | 1 | Latched vertical guard failure |
| stat_flash | output | 1 | Latched flash event |
| stat_kill | output | 1 | Latched protection stop |

## Verification
On every cycle, the assertions check the following: the drive never rises without full permission, `duty` moves by at most one and only on a line tick, the drive only falls at zero duty, and discharge never overlaps drive. They also check that the X-ray flag is sticky, that a latched stop blocks restart, and that the blanking and overscan outputs follow their enables. Only the bench scenarios can show the exact ramp timing. This covers the step-phase arithmetic across a reversal, the discharge length, and the behaviour of each protection mode over the full stop sequence.

// File: rtl/hdg_pkg.sv
`timescale 1ns/1ps
package hdg_pkg;

  typedef enum logic [2:0] {
    ST_OFF  = 3'd0,
    ST_UP   = 3'd1,
    ST_RUN  = 3'd2,
    ST_DOWN = 3'd3,
    ST_DIS  = 3'd4
  } hdg_state_e;

  // drive is on in both ramps and in steady run
  function automatic logic drive_on(input hdg_state_e s);
    return (s == ST_UP) || (s == ST_RUN) || (s == ST_DOWN);
  endfunction

  function automatic logic ramping(input hdg_state_e s);
    return (s == ST_UP) || (s == ST_DOWN);
  endfunction

  // permission to run the horizontal drive
  function automatic logic drive_permit(input logic por, input logic cfg,
                                        input logic run, input logic kill);
    return !por && cfg && run && !kill;
  endfunction

endpackage

// File: rtl/hdg_line_cnt.sv
`timescale 1ns/1ps
module hdg_line_cnt #(
  parameter int LIMIT = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic active,
  input  logic line_tick,
  output logic hit
);
  localparam int CW = (LIMIT > 1) ? $clog2(LIMIT) : 1;
  localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

  logic [CW-1:0] cnt;

  assign hit = active && line_tick && (cnt == LAST);

  always_ff @(posedge clk) begin
    if (!rst_n || !active) cnt <= '0;
    else if (line_tick)    cnt <= (cnt == LAST) ? '0 : cnt + CW'(1);
  end
endmodule

// File: rtl/hdg_prot_latch.sv
`timescale 1ns/1ps
module hdg_prot_latch (
  input  logic clk,
  input  logic rst_n,
  input  logic xray_trip,
  input  logic vguard_fail,
  input  logic flash_trip,
  input  logic xray_flag_only,
  input  logic flash_ignore,
  output logic stat_xray,
  output logic stat_vguard,
  output logic stat_flash,
  output logic kill
);
  logic kill_evt;
  assign kill_evt = (xray_trip && !xray_flag_only) || (flash_trip && !flash_ignore);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stat_xray   <= 1'b0;
      stat_vguard <= 1'b0;
      stat_flash  <= 1'b0;
      kill        <= 1'b0;
    end else begin
      stat_xray   <= stat_xray   | xray_trip;
      stat_vguard <= stat_vguard | vguard_fail;
      stat_flash  <= stat_flash  | flash_trip;
      kill        <= kill        | kill_evt;
    end
  end
endmodule

// File: rtl/hdrive_guard_seq.sv
`timescale 1ns/1ps
module hdrive_guard_seq
  import hdg_pkg::*;
#(
  parameter int LEVEL_W    = 8,
  parameter int STEP_LINES = 4,
  parameter int DIS_LINES  = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               line_tick,
  input  logic               run_req,
  input  logic               cfg_done,
  input  logic               por_flag,
  input  logic               blk_force,
  input  logic               rgb_low_req,
  input  logic               xray_flag_only,
  input  logic               vguard_blank_en,
  input  logic               flash_ignore,
  input  logic               overscan_hold_en,
  input  logic               xray_trip,
  input  logic               vguard_fail,
  input  logic               flash_trip,
  output logic               hdrv_en,
  output logic [LEVEL_W-1:0] duty,
  output logic               rgb_blank,
  output logic               bcl_en,
  output logic               discharge_on,
  output logic               overscan_hold,
  output logic               stat_xray,
  output logic               stat_vguard,
  output logic               stat_flash,
  output logic               stat_kill
);
  localparam logic [LEVEL_W-1:0] LVL_MAX = {LEVEL_W{1'b1}};
  localparam logic [LEVEL_W-1:0] LVL_ONE = LEVEL_W'(1);

  hdg_state_e         state, state_nx;
  logic [LEVEL_W-1:0] level, level_nx;

  // named internal events
  logic kill;
  logic permit;
  logic step;
  logic dis_done;
  logic in_ramp;
  logic in_dis;
  logic vg_blank;

  assign in_ramp = ramping(state);
  assign in_dis  = (state == ST_DIS);
  assign permit  = drive_permit(por_flag, cfg_done, run_req, kill);

  hdg_prot_latch u_prot (
    .clk            (clk),
    .rst_n          (rst_n),
    .xray_trip      (xray_trip),
    .vguard_fail    (vguard_fail),
    .flash_trip     (flash_trip),
    .xray_flag_only (xray_flag_only),
    .flash_ignore   (flash_ignore),
    .stat_xray      (stat_xray),
    .stat_vguard    (stat_vguard),
    .stat_flash     (stat_flash),
    .kill           (kill)
  );

  // step phase survives a ramp reversal: active over both ramp states
  hdg_line_cnt #(.LIMIT(STEP_LINES)) u_step (
    .clk       (clk),
    .rst_n     (rst_n),
    .active    (in_ramp),
    .line_tick (line_tick),
    .hit       (step)
  );

  hdg_line_cnt #(.LIMIT(DIS_LINES)) u_dis (
    .clk       (clk),
    .rst_n     (rst_n),
    .active    (in_dis),
    .line_tick (line_tick),
    .hit       (dis_done)
  );

  always_comb begin
    state_nx = state;
    level_nx = level;
    unique case (state)
      ST_OFF: begin
        level_nx = '0;
        if (permit) state_nx = ST_UP;
      end
      ST_UP: begin
        if (!permit)               state_nx = ST_DOWN;
        else if (level == LVL_MAX) state_nx = ST_RUN;
        else if (step)             level_nx = level + LVL_ONE;
      end
      ST_RUN: begin
        if (!permit) state_nx = ST_DOWN;
      end
      ST_DOWN: begin
        if (permit)           state_nx = ST_UP;
        else if (level == '0) state_nx = ST_DIS;
        else if (step)        level_nx = level - LVL_ONE;
      end
      ST_DIS: begin
        if (dis_done) state_nx = ST_OFF;
      end
      default: state_nx = ST_OFF;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= ST_OFF;
      level <= '0;
    end else begin
      state <= state_nx;
      level <= level_nx;
    end
  end

  assign vg_blank      = vguard_blank_en && vguard_fail;
  assign hdrv_en       = drive_on(state);
  assign duty          = level;
  assign discharge_on  = in_dis && !blk_force;
  assign rgb_blank     = rgb_low_req || vg_blank || (in_dis && blk_force);
  assign bcl_en        = !rgb_blank;
  assign overscan_hold = overscan_hold_en && (in_dis || (state == ST_DOWN));
  assign stat_kill     = kill;
endmodule

// File: rtl/hdg_chk.sv
`timescale 1ns/1ps
module hdg_chk #(
  parameter int LEVEL_W = 8
) (
  input logic               clk,
  input logic               rst_n,
  input logic               line_tick,
  input logic               por_flag,
  input logic               cfg_done,
  input logic               run_req,
  input logic               kill,
  input logic               hdrv_en,
  input logic [LEVEL_W-1:0] duty,
  input logic               discharge_on,
  input logic               stat_xray,
  input logic               vguard_blank_en,
  input logic               vguard_fail,
  input logic               rgb_low_req,
  input logic               rgb_blank,
  input logic               bcl_en,
  input logic               overscan_hold,
  input logic               overscan_hold_en
);
  localparam logic [LEVEL_W-1:0] ONE = LEVEL_W'(1);

  // R1
  drive_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hdrv_en) |-> $past(!por_flag && cfg_done && run_req && !kill));

  // R2
  duty_unit_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (duty != $past(duty)) |->
      ((LEVEL_W'(duty - $past(duty)) == ONE) || (LEVEL_W'($past(duty) - duty) == ONE)));

  // R3
  no_tick_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(line_tick) |-> $stable(duty));

  // R4
  drive_off_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(hdrv_en) |-> (duty == '0));

  // R6
  discharge_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    discharge_on |-> !hdrv_en);

  // R7
  xray_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(stat_xray) |-> stat_xray);

  // R7
  kill_no_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(kill) |-> !$rose(hdrv_en));

  // R9
  vguard_blank_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (vguard_blank_en && vguard_fail) |-> rgb_blank);

  // R11
  overscan_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
    overscan_hold |-> (overscan_hold_en && (hdrv_en || discharge_on || rgb_blank)));

  // R12
  rgbl_force_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rgb_low_req |-> (rgb_blank && !bcl_en));
endmodule

bind hdrive_guard_seq hdg_chk #(.LEVEL_W(LEVEL_W)) u_hdg_chk (
  .clk              (clk),
  .rst_n            (rst_n),
  .line_tick        (line_tick),
  .por_flag         (por_flag),
  .cfg_done         (cfg_done),
  .run_req          (run_req),
  .kill             (kill),
  .hdrv_en          (hdrv_en),
  .duty             (duty),
  .discharge_on     (discharge_on),
  .stat_xray        (stat_xray),
  .vguard_blank_en  (vguard_blank_en),
  .vguard_fail      (vguard_fail),
  .rgb_low_req      (rgb_low_req),
  .rgb_blank        (rgb_blank),
  .bcl_en           (bcl_en),
  .overscan_hold    (overscan_hold),
  .overscan_hold_en (overscan_hold_en)
);

// File: tb/hdrive_guard_seq_bench.sv
`timescale 1ns/1ps
module hdrive_guard_seq_bench;
  localparam int LW   = 4;
  localparam int NS   = 3;
  localparam int ND   = 5;
  localparam int MAXV = (1 << LW) - 1;
  localparam int RAMP = MAXV * NS;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic line_tick, run_req, cfg_done, por_flag, blk_force, rgb_low_req;
  logic xray_flag_only, vguard_blank_en, flash_ignore, overscan_hold_en;
  logic xray_trip, vguard_fail, flash_trip;
  logic hdrv_en, rgb_blank, bcl_en, discharge_on, overscan_hold;
  logic stat_xray, stat_vguard, stat_flash, stat_kill;
  logic [LW-1:0] duty;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  hdrive_guard_seq #(.LEVEL_W(LW), .STEP_LINES(NS), .DIS_LINES(ND)) u_hdrive_guard_seq (
    .clk(clk), .rst_n(rst_n), .line_tick(line_tick), .run_req(run_req),
    .cfg_done(cfg_done), .por_flag(por_flag), .blk_force(blk_force),
    .rgb_low_req(rgb_low_req), .xray_flag_only(xray_flag_only),
    .vguard_blank_en(vguard_blank_en), .flash_ignore(flash_ignore),
    .overscan_hold_en(overscan_hold_en), .xray_trip(xray_trip),
    .vguard_fail(vguard_fail), .flash_trip(flash_trip), .hdrv_en(hdrv_en),
    .duty(duty), .rgb_blank(rgb_blank), .bcl_en(bcl_en),
    .discharge_on(discharge_on), .overscan_hold(overscan_hold),
    .stat_xray(stat_xray), .stat_vguard(stat_vguard),
    .stat_flash(stat_flash), .stat_kill(stat_kill)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic nedge(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    line_tick = 1'b1; run_req = 1'b0; cfg_done = 1'b1; por_flag = 1'b0;
    blk_force = 1'b0; rgb_low_req = 1'b0; xray_flag_only = 1'b0;
    vguard_blank_en = 1'b0; flash_ignore = 1'b0; overscan_hold_en = 1'b0;
    xray_trip = 1'b0; vguard_fail = 1'b0; flash_trip = 1'b0;
    nedge(3);
    rst_n = 1'b1;
    nedge(1);
  endtask

  // raise run_req and wait until steady run (one cycle after max duty)
  task automatic to_run();
    run_req = 1'b1;
    nedge(1);
    nedge(RAMP + 1);
    chk("R2 run reached duty", int'(duty), MAXV);
  endtask

  initial begin
    do_reset();
    // R13 reset state
    chk("R13 hdrv_en", int'(hdrv_en), 0);
    chk("R13 duty", int'(duty), 0);
    chk("R13 rgb_blank", int'(rgb_blank), 0);
    chk("R13 bcl_en", int'(bcl_en), 1);
    chk("R13 discharge_on", int'(discharge_on), 0);
    chk("R13 flags", int'({stat_xray, stat_vguard, stat_flash, stat_kill}), 0);

    // R1 sweep of permission qualifiers
    for (int c = 0; c < 8; c++) begin
      do_reset();
      por_flag = c[0]; cfg_done = c[1]; run_req = c[2];
      nedge(6);
      chk("R1 permit combo", int'(hdrv_en), (c == 6) ? 1 : 0);
    end

    // R2 full soft-start sweep
    do_reset();
    run_req = 1'b1;
    nedge(1);
    for (int j = 0; j <= RAMP + 2; j++) begin
      chk("R2 ramp duty", int'(duty), (j >= RAMP) ? MAXV : j / NS);
      chk("R2 drive on", int'(hdrv_en), 1);
      nedge(1);
    end

    // R3 missing line ticks hold the ramp and its phase
    do_reset();
    run_req = 1'b1;
    nedge(1);
    nedge(4);
    chk("R3 pre-gap duty", int'(duty), 1);
    line_tick = 1'b0;
    nedge(10);
    chk("R3 gap duty held", int'(duty), 1);
    line_tick = 1'b1;
    nedge(1);
    chk("R3 phase kept, no step yet", int'(duty), 1);
    nedge(1);
    chk("R3 step after resume", int'(duty), 2);

    // R4 R6 R11 soft stop and discharge over blk_force x overscan_hold_en
    for (int c = 0; c < 4; c++) begin
      do_reset();
      blk_force = c[0];
      overscan_hold_en = c[1];
      to_run();
      chk("R11 no hold in run", int'(overscan_hold), 0);
      run_req = 1'b0;
      nedge(1);
      for (int j = 0; j <= RAMP + ND + 3; j++) begin
        if (j <= RAMP) begin
          chk("R4 stop duty", int'(duty), MAXV - j / NS);
          chk("R4 drive on in stop", int'(hdrv_en), 1);
          chk("R11 hold in stop", int'(overscan_hold), c[1]);
        end else if (j <= RAMP + ND) begin
          chk("R6 drive off in discharge", int'(hdrv_en), 0);
          chk("R6 discharge current", int'(discharge_on), c[0] ? 0 : 1);
          chk("R6 discharge blank", int'(rgb_blank), c[0] ? 1 : 0);
          chk("R11 hold in discharge", int'(overscan_hold), c[1]);
        end else begin
          chk("R6 back to off", int'({hdrv_en, discharge_on, rgb_blank, overscan_hold}), 0);
          chk("R6 off duty", int'(duty), 0);
        end
        nedge(1);
      end
    end

    // R5 reversal during ramp-up
    do_reset();
    run_req = 1'b1;
    nedge(1);
    nedge(10);
    chk("R5 pre-reverse duty", int'(duty), 3);
    run_req = 1'b0;
    nedge(1);
    for (int j = 11; j <= 18; j++) begin
      chk("R5 reversed down duty", int'(duty), 6 - j / NS);
      chk("R5 drive on", int'(hdrv_en), 1);
      nedge(1);
    end
    chk("R5 discharge after reverse", int'(hdrv_en), 0);

    // R5 reversal during ramp-down
    do_reset();
    to_run();
    run_req = 1'b0;
    nedge(1);
    nedge(10);
    chk("R5 pre-reverse down duty", int'(duty), MAXV - 3);
    run_req = 1'b1;
    nedge(1);
    for (int j = 11; j <= 21; j++) begin
      chk("R5 reversed up duty", int'(duty), (9 + j / NS > MAXV) ? MAXV : 9 + j / NS);
      nedge(1);
    end
    chk("R5 drive kept", int'(hdrv_en), 1);

    // R7 X-ray with automatic stop
    do_reset();
    to_run();
    xray_trip = 1'b1;
    nedge(1);
    xray_trip = 1'b0;
    chk("R7 xray flag", int'(stat_xray), 1);
    chk("R7 kill latched", int'(stat_kill), 1);
    chk("R7 still at full before stop", int'(duty), MAXV);
    nedge(RAMP + ND + 10);
    chk("R7 drive stopped", int'(hdrv_en), 0);
    chk("R7 duty zero", int'(duty), 0);
    nedge(20);
    chk("R7 no restart", int'(hdrv_en), 0);
    chk("R7 flag sticky", int'(stat_xray), 1);

    // R8 X-ray flag only
    do_reset();
    xray_flag_only = 1'b1;
    to_run();
    xray_trip = 1'b1;
    nedge(1);
    xray_trip = 1'b0;
    chk("R8 xray flag", int'(stat_xray), 1);
    chk("R8 no kill", int'(stat_kill), 0);
    nedge(20);
    chk("R8 drive kept", int'(hdrv_en), 1);
    chk("R8 duty kept", int'(duty), MAXV);

    // R9 vertical guard, both modes
    for (int e = 0; e < 2; e++) begin
      do_reset();
      vguard_blank_en = e[0];
      to_run();
      vguard_fail = 1'b1;
      #1;
      chk("R9 blank same cycle", int'(rgb_blank), e);
      nedge(1);
      chk("R9 blank while failing", int'(rgb_blank), e);
      chk("R9 status", int'(stat_vguard), 1);
      vguard_fail = 1'b0;
      nedge(1);
      chk("R9 blank released", int'(rgb_blank), 0);
      chk("R9 status sticky", int'(stat_vguard), 1);
      chk("R9 drive unaffected", int'(hdrv_en), 1);
    end

    // R10 flash, both modes
    for (int f = 0; f < 2; f++) begin
      do_reset();
      flash_ignore = f[0];
      to_run();
      flash_trip = 1'b1;
      nedge(1);
      flash_trip = 1'b0;
      chk("R10 flash flag", int'(stat_flash), 1);
      chk("R10 kill", int'(stat_kill), f ? 0 : 1);
      nedge(RAMP + ND + 10);
      chk("R10 drive after flash", int'(hdrv_en), f);
    end

    // R12 RGB low request
    do_reset();
    to_run();
    rgb_low_req = 1'b1;
    nedge(1);
    chk("R12 blank", int'(rgb_blank), 1);
    chk("R12 bcl off", int'(bcl_en), 0);
    chk("R12 drive unaffected", int'(hdrv_en), 1);
    rgb_low_req = 1'b0;
    nedge(1);
    chk("R12 released blank", int'(rgb_blank), 0);
    chk("R12 released bcl", int'(bcl_en), 1);

    if (!done) begin
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule